// File: doc/BRIEF.md
# Per-Port Source Address Change Detector

This block sits beside a multi-port repeater and remembers, for every port, the 48-bit source MAC address of the most recent frame seen on that port. The receive path hands it one validated strobe per frame, with the port number and the source address. The block compares that address with the stored one for the same port. When the two differ it replaces the stored value and, if change reporting is enabled for that port, emits a one-cycle change event tagged with the port number.

There are `NUM_TP` twisted-pair ports, numbered 0 to `NUM_TP-1`, and one attachment port at index `NUM_TP`. The host can preload the stored address of any port. This suits a port known to serve a single station: frames from that station then raise no event. A port whose stored address has never been written, by the host or by a frame, takes the address of its first frame, and that first capture always counts as a change. The host reads any port's stored address and its valid flag through a combinational read port.

Top module: `sacd_top`

## Requirements
- R1: After reset, every port's valid flag reads 0 and `chg_evt` is 0.
- R2: A frame on a port whose valid flag is 0 stores the frame's address, sets the valid flag, and counts as a change.
- R3: A frame whose address differs from the valid stored address replaces the stored value and counts as a change.
- R4: A change on a port whose enable is 0 still updates the stored address and valid flag, but raises no event.
- R5: A frame whose address equals the valid stored address raises no event and leaves the stored value unchanged.
- R6: A host write sets the port's stored address to `host_wdata` and its valid flag to 1. A later frame carrying that same address raises no event.
- R7: When a host write and a frame target the same port in the same cycle, the host value is kept and the frame raises no event. When they target different ports, both take effect.
- R8: Bit i of `tp_chg_en` enables events for port i (i < `NUM_TP`). `aux_chg_en` enables events for port `NUM_TP` only.
- R9: A frame whose port index is `NUM_TP+1` or higher changes no stored state and raises no event. Reading such an index returns a valid flag of 0.
- R10: An event appears on `chg_evt`, with the port number on `chg_port`, for exactly the one cycle after the clock edge that samples the frame strobe. `rd_addr` and `rd_valid` show the updated value after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld | input | 1 | One-cycle strobe for a validated received frame |
| frm_port | input | PW | Port index of the frame |
| frm_sa | input | 48 | Source address of the frame |
| host_we | input | 1 | Host write of a stored address |
| host_port | input | PW | Port index of the host write |
| host_wdata | input | 48 | Address written by the host |
| tp_chg_en | input | NUM_TP | Per-port change enables for the twisted-pair ports |
| aux_chg_en | input | 1 | Change enable for the attachment port |
| rd_port | input | PW | Port index for host readback |
| rd_addr | output | 48 | Stored address of `rd_port` |
| rd_valid | output | 1 | Valid flag of `rd_port` |
| chg_evt | output | 1 | One-cycle change event |
| chg_port | output | PW | Port that produced the event |

## Verification
A stuck or wrongly set valid flag shows up on the very first frame after reset on that port. The port then either misses its first-capture event or reports an event against a stale address, and `rd_valid` shows the bad flag at once. A stored address corrupted by a wrong write priority or a wrong index is visible on `rd_addr` one edge after the offending cycle. It also shows one edge after the next frame on that port, as a missing or spurious event. Enable mis-mapping shows as an event, or its absence, on the wrong port one cycle after the strobe.

// File: rtl/sacd_pkg.sv
package sacd_pkg;
  parameter int unsigned MAC_W = 48;
  typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/sacd_store.sv
module sacd_store
  import sacd_pkg::*;
#(
  parameter int unsigned NPORTS = 9,
  parameter int unsigned PW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [PW-1:0] host_port,
  input  mac_t          host_data,
  input  logic          cap_we,
  input  logic [PW-1:0] cap_port,
  input  mac_t          cap_data,
  input  logic [PW-1:0] lk_port,
  output mac_t          lk_addr,
  output logic          lk_valid,
  input  logic [PW-1:0] rd_port,
  output mac_t          rd_addr,
  output logic          rd_valid
);

  mac_t              addr_q [NPORTS];
  logic [NPORTS-1:0] valid_q;

  for (genvar g = 0; g < NPORTS; g++) begin : g_entry
    logic host_hit, cap_hit, ld;
    mac_t addr_d;

    always_comb begin
      host_hit = host_we && (host_port == PW'(g));
      cap_hit  = cap_we && (cap_port == PW'(g));
      ld       = host_hit || cap_hit;
      addr_d   = host_hit ? host_data : cap_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (ld) begin
        addr_q[g]  <= addr_d;
        valid_q[g] <= 1'b1;
      end
    end

    a_r6_host_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      host_hit |=> (valid_q[g] && addr_q[g] == $past(host_data)));

    a_r1_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[g] |=> valid_q[g]);
  end

  always_comb begin
    lk_addr  = '0;
    lk_valid = 1'b0;
    rd_addr  = '0;
    rd_valid = 1'b0;
    for (int i = 0; i < NPORTS; i++) begin
      if (lk_port == PW'(i)) begin
        lk_addr  = addr_q[i];
        lk_valid = valid_q[i];
      end
      if (rd_port == PW'(i)) begin
        rd_addr  = addr_q[i];
        rd_valid = valid_q[i];
      end
    end
  end

endmodule

// File: rtl/sacd_detect.sv
module sacd_detect
  import sacd_pkg::*;
#(
  parameter int unsigned NPORTS = 9,
  parameter int unsigned PW     = 4
) (
  input  logic              frm_vld,
  input  logic [PW-1:0]     frm_port,
  input  mac_t              frm_sa,
  input  mac_t              lk_addr,
  input  logic              lk_valid,
  input  logic [NPORTS-1:0] en_vec,
  input  logic              host_we,
  input  logic [PW-1:0]     host_port,
  output logic              cap_we,
  output logic              evt_d
);

  logic in_range, differs, collide, en_sel;

  always_comb begin
    in_range = ({1'b0, frm_port} < (PW+1)'(NPORTS));
    differs  = !lk_valid || (lk_addr != frm_sa);
    collide  = host_we && (host_port == frm_port);
    en_sel   = 1'b0;
    for (int i = 0; i < NPORTS; i++) begin
      if (frm_port == PW'(i)) en_sel = en_vec[i];
    end
    cap_we = frm_vld && in_range && differs && !collide;
    evt_d  = cap_we && en_sel;
  end

endmodule

// File: rtl/sacd_top.sv
module sacd_top
  import sacd_pkg::*;
#(
  parameter int unsigned NUM_TP = 8,
  parameter int unsigned NPORTS = NUM_TP + 1,
  parameter int unsigned PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_vld,
  input  logic [PW-1:0]     frm_port,
  input  logic [MAC_W-1:0]  frm_sa,
  input  logic              host_we,
  input  logic [PW-1:0]     host_port,
  input  logic [MAC_W-1:0]  host_wdata,
  input  logic [NUM_TP-1:0] tp_chg_en,
  input  logic              aux_chg_en,
  input  logic [PW-1:0]     rd_port,
  output logic [MAC_W-1:0]  rd_addr,
  output logic              rd_valid,
  output logic              chg_evt,
  output logic [PW-1:0]     chg_port
);

  mac_t              lk_addr;
  logic              lk_valid;
  logic              cap_we, evt_d;
  logic [NPORTS-1:0] en_vec;
  logic              evt_q;
  logic [PW-1:0]     port_q, port_d;

  assign en_vec = {aux_chg_en, tp_chg_en};

  sacd_store #(.NPORTS(NPORTS), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_port(host_port), .host_data(host_wdata),
    .cap_we(cap_we), .cap_port(frm_port), .cap_data(frm_sa),
    .lk_port(frm_port), .lk_addr(lk_addr), .lk_valid(lk_valid),
    .rd_port(rd_port), .rd_addr(rd_addr), .rd_valid(rd_valid)
  );

  sacd_detect #(.NPORTS(NPORTS), .PW(PW)) u_det (
    .frm_vld(frm_vld), .frm_port(frm_port), .frm_sa(frm_sa),
    .lk_addr(lk_addr), .lk_valid(lk_valid), .en_vec(en_vec),
    .host_we(host_we), .host_port(host_port),
    .cap_we(cap_we), .evt_d(evt_d)
  );

  always_comb port_d = evt_d ? frm_port : port_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      port_q <= '0;
    end else begin
      evt_q  <= evt_d;
      port_q <= port_d;
    end
  end

  assign chg_evt  = evt_q;
  assign chg_port = port_q;

  a_r10_evt_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> $past(frm_vld));

  a_r9_out_of_range_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && ({1'b0, frm_port} >= (PW+1)'(NPORTS))) |=> !chg_evt);

  a_r5_equal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && lk_valid && lk_addr == frm_sa) |=> !chg_evt);

  a_r7_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && host_we && host_port == frm_port) |=> !chg_evt);

endmodule

// File: tb/sim_sacd_top.sv
`timescale 1ns/1ps
module sim_sacd_top;
  localparam int NUM_TP = 8;
  localparam int PW = 4;

  logic clk = 0, rst_n = 0;
  logic frm_vld = 0, host_we = 0, aux_chg_en = 0;
  logic [PW-1:0] frm_port = 0, host_port = 0, rd_port = 0;
  logic [47:0] frm_sa = 0, host_wdata = 0;
  logic [NUM_TP-1:0] tp_chg_en = 0;
  logic [47:0] rd_addr;
  logic rd_valid, chg_evt;
  logic [PW-1:0] chg_port;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sacd_top #(.NUM_TP(NUM_TP)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_port(frm_port), .frm_sa(frm_sa),
    .host_we(host_we), .host_port(host_port), .host_wdata(host_wdata),
    .tp_chg_en(tp_chg_en), .aux_chg_en(aux_chg_en), .rd_port(rd_port),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .chg_evt(chg_evt), .chg_port(chg_port)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit fv, input int fp, input logic [47:0] sa,
                       input bit hw, input int hp, input logic [47:0] hd);
    @(negedge clk);
    frm_vld = fv; frm_port = PW'(fp); frm_sa = sa;
    host_we = hw; host_port = PW'(hp); host_wdata = hd;
    @(posedge clk); #1;
    frm_vld = 0; host_we = 0;
  endtask

  task automatic frame(int p, logic [47:0] sa);
    cycle(1, p, sa, 0, 0, '0);
  endtask

  task automatic peek(int p, bit v, logic [47:0] a, string req);
    rd_port = PW'(p); #1;
    check({req, " valid"}, 64'(rd_valid), 64'(v));
    if (v) check({req, " addr"}, 64'(rd_addr), 64'(a));
  endtask

  task automatic t_reset();
    check("R1 evt", 64'(chg_evt), 0);
    peek(0, 0, 0, "R1 p0");
    peek(8, 0, 0, "R1 p8");
  endtask

  task automatic t_first_and_diff();
    frame(0, 48'hA1);
    check("R2 evt", 64'(chg_evt), 1);
    check("R10 port", 64'(chg_port), 0);
    peek(0, 1, 48'hA1, "R2");
    cycle(0, 0, '0, 0, 0, '0);
    check("R10 one cycle", 64'(chg_evt), 0);
    frame(0, 48'hB2);
    check("R3 evt", 64'(chg_evt), 1);
    peek(0, 1, 48'hB2, "R3");
    frame(0, 48'hB2);
    check("R5 evt", 64'(chg_evt), 0);
    peek(0, 1, 48'hB2, "R5");
  endtask

  task automatic t_disabled();
    tp_chg_en[1] = 0;
    frame(1, 48'hC3);
    check("R4 first evt", 64'(chg_evt), 0);
    peek(1, 1, 48'hC3, "R4 first");
    frame(1, 48'hD4);
    check("R4 diff evt", 64'(chg_evt), 0);
    peek(1, 1, 48'hD4, "R4 diff");
    tp_chg_en[1] = 1;
  endtask

  task automatic t_host();
    cycle(0, 0, '0, 1, 2, 48'hE5);
    peek(2, 1, 48'hE5, "R6 write");
    frame(2, 48'hE5);
    check("R6 equal evt", 64'(chg_evt), 0);
    frame(2, 48'hF6);
    check("R6 diff evt", 64'(chg_evt), 1);
    check("R6 port", 64'(chg_port), 2);
  endtask

  task automatic t_collide();
    cycle(1, 3, 48'h77, 1, 3, 48'h66);
    check("R7 same evt", 64'(chg_evt), 0);
    peek(3, 1, 48'h66, "R7 same");
    cycle(1, 5, 48'h99, 1, 4, 48'h88);
    check("R7 split evt", 64'(chg_evt), 1);
    check("R7 split port", 64'(chg_port), 5);
    peek(4, 1, 48'h88, "R7 host side");
    peek(5, 1, 48'h99, "R7 frame side");
  endtask

  task automatic t_aux();
    aux_chg_en = 0;
    frame(8, 48'h1234);
    check("R8 aux off", 64'(chg_evt), 0);
    aux_chg_en = 1;
    tp_chg_en = '0;
    frame(8, 48'h5678);
    check("R8 aux on", 64'(chg_evt), 1);
    check("R8 aux port", 64'(chg_port), 8);
    frame(6, 48'hAB);
    check("R8 tp off aux on", 64'(chg_evt), 0);
    tp_chg_en = '1;
  endtask

  task automatic t_range();
    frame(9, 48'h1);
    check("R9 p9 evt", 64'(chg_evt), 0);
    frame(15, 48'h2);
    check("R9 p15 evt", 64'(chg_evt), 0);
    peek(9, 0, 0, "R9 p9");
    peek(7, 0, 0, "R9 p7 untouched");
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rst_n = 1;
    tp_chg_en = '1;
    t_first_and_diff();
    t_disabled();
    t_host();
    t_collide();
    t_aux();
    t_range();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule